// File: doc/BRIEF.md
# Timer Clock Source Switch Controller

This block controls the clock feeding a timer. Software writes one control word that holds an enable bit and a source-select field. The block passes both values to its outputs only after a fixed synchronization delay. While that delay runs, a busy flag is high and the control word is locked.

A different source may be chosen only while the clock is stopped. The safe way to switch is:

1. Write the word with the enable bit cleared and the select field unchanged, then wait for busy to fall.
2. Write the new select value, then wait for busy to fall.
3. Write the word with the enable bit set and the select field unchanged, then wait for busy to fall.

The block drops any write that arrives while busy is high and records it in a sticky error flag. It also ignores any write that tries to move the select field while the stored enable bit is set.

Top module: `clk_src_switch`

## Requirements
- R1: After reset `clk_en_out` is 0, `sel_out` is 0, `busy` is 0 and `err` is 0.
- R2: A write that changes the enable bit or the select field is accepted. `busy` is high for exactly DELAY cycles (default 3), starting the cycle after the accepting edge.
- R3: `clk_en_out` keeps its old value while `busy` is high. It takes the newly written enable value at the edge where `busy` falls.
- R4: With the stored enable bit at 0, a write of a new select value is accepted. `sel_out` keeps its old value while `busy` is high and takes the new value when `busy` falls.
- R5: With the stored enable bit at 1, a write whose select field differs from the stored one is ignored as a whole. `busy` stays low, and `clk_en_out` and `sel_out` are unchanged.
- R6: A write that arrives while `busy` is high is dropped and sets `err`. The outputs then settle to the values of the accepted write.
- R7: `err` stays at 1 until reset, whatever is written afterwards.
- R8: A write that matches the stored enable bit and select field leaves `busy` low and changes no output.
- R9: With the stored enable bit at 0, a single write may set the enable bit and change the select field. After the delay, both outputs carry the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control-word write strobe, one cycle per write |
| wr_enable | input | 1 | Enable bit of the written word |
| wr_sel | input | SEL_W | Source-select field of the written word |
| busy | output | 1 | High while an accepted change is propagating |
| clk_en_out | output | 1 | Enable of the timer clock after the delay |
| sel_out | output | SEL_W | Source select after the delay |
| err | output | 1 | Sticky flag for writes dropped while busy |

## Verification
The main sweep visits every pairing of starting state and written word for a 2-bit select field. A starting state is an enable value with a select value, and every starting state is reached through the legal switch sequence.

The sweep separates three outcomes:
- changes that must raise busy for exactly three cycles, split by whether the enable bit, the select field or both change;
- no-change writes that must leave busy low;
- select changes attempted while running, which must be ignored entirely.

Separate patterns send a second write into the busy window and keep writing after the error flag is set. These show that a dropped write does not alter the outputs and that the error flag only clears on reset.

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int SEL_W = 2,
  parameter int DELAY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_enable,
  input  logic [SEL_W-1:0] wr_sel,
  output logic             busy,
  output logic             clk_en_out,
  output logic [SEL_W-1:0] sel_out,
  output logic             err
);
  localparam int CW = $clog2(DELAY + 1);

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt;

  assign busy = (cnt != '0);

  wire sel_locked = en_q && (wr_sel != sel_q);
  wire accept     = wr_en && !busy && !sel_locked;
  wire change     = accept && ((wr_enable != en_q) || (wr_sel != sel_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      sel_q      <= '0;
      cnt        <= '0;
      clk_en_out <= 1'b0;
      sel_out    <= '0;
      err        <= 1'b0;
    end else begin
      if (wr_en && busy) err <= 1'b1;
      if (change) begin
        en_q  <= wr_enable;
        sel_q <= wr_sel;
        cnt   <= CW'(DELAY);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (cnt == CW'(1)) begin
        clk_en_out <= en_q;
        sel_out    <= sel_q;
      end
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_busy_write_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> err);
  assert_busy_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(en_q) && $stable(sel_q)));
  assert_outputs_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(clk_en_out) && $stable(sel_out)));
  assert_sel_fixed_while_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |=> $stable(sel_out));
  assert_locked_write_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && en_q && (wr_sel != sel_q)) |=> !busy);
endmodule

// File: tb/clk_src_switch_test.sv
module clk_src_switch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_enable = 1'b0;
  logic [1:0] wr_sel = '0;
  logic       busy, clk_en_out, err;
  logic [1:0] sel_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic       m_en = 1'b0;
  logic [1:0] m_sel = '0;

  clk_src_switch #(.SEL_W(2), .DELAY(3)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_enable(wr_enable),
    .wr_sel(wr_sel), .busy(busy), .clk_en_out(clk_en_out),
    .sel_out(sel_out), .err(err));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drives one write, counts busy cycles and compares against the model.
  task automatic wr(input logic e, input logic [1:0] s, input string req);
    logic ignored, changed;
    int n;
    logic old_en;
    logic [1:0] old_sel;
    ignored = m_en && (s != m_sel);
    changed = !ignored && ((e != m_en) || (s != m_sel));
    old_en  = m_en;
    old_sel = m_sel;
    @(negedge clk);
    wr_en = 1'b1; wr_enable = e; wr_sel = s;
    @(negedge clk);
    wr_en = 1'b0;
    if (changed) begin
      check(req, "clk_en_out held during busy", clk_en_out, old_en);
      check(req, "sel_out held during busy", sel_out, old_sel);
    end
    n = 0;
    while (busy && n < 10) begin
      n++;
      @(negedge clk);
    end
    check(req, "busy length", n, changed ? 3 : 0);
    if (changed) begin m_en = e; m_sel = s; end
    check(req, "clk_en_out settled", clk_en_out, m_en);
    check(req, "sel_out settled", sel_out, m_sel);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "clk_en_out after reset", clk_en_out, 0);
    check("R1", "sel_out after reset", sel_out, 0);
    check("R1", "busy after reset", busy, 0);
    check("R1", "err after reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(1'b1, 2'd0, "R2");
    wr(1'b1, 2'd2, "R5");
    wr(1'b1, 2'd0, "R8");
    wr(1'b0, 2'd0, "R3");
    wr(1'b0, 2'd3, "R4");
    wr(1'b1, 2'd1, "R9");

    for (int e0 = 0; e0 < 2; e0++)
      for (int s0 = 0; s0 < 4; s0++)
        for (int e1 = 0; e1 < 2; e1++)
          for (int s1 = 0; s1 < 4; s1++) begin
            wr(1'b0, m_sel, "R3");
            wr(1'b0, 2'(s0), "R4");
            wr(1'(e0), 2'(s0), "R2");
            wr(1'(e1), 2'(s1), (e0 == 1 && s1 != s0) ? "R5" :
                                (e0 == 0 && e1 == 1 && s1 != s0) ? "R9" :
                                (e0 == e1 && s0 == s1) ? "R8" : "R2");
          end
    check("R7", "err stays low without busy writes", err, 0);

    wr(1'b0, m_sel, "R3");
    @(negedge clk);
    wr_en = 1'b1; wr_enable = 1'b1; wr_sel = 2'd1;
    @(negedge clk);
    wr_en = 1'b1; wr_enable = 1'b0; wr_sel = 2'd2;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6", "err after busy write", err, 1);
    repeat (4) @(negedge clk);
    check("R6", "clk_en_out after dropped write", clk_en_out, 1);
    check("R6", "sel_out after dropped write", sel_out, 1);
    m_en = 1'b1; m_sel = 2'd1;

    wr(1'b0, 2'd1, "R7");
    wr(1'b0, 2'd3, "R7");
    check("R7", "err still set", err, 1);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "err cleared by reset", err, 0);
    check("R1", "clk_en_out cleared by reset", clk_en_out, 0);
    check("R1", "sel_out cleared by reset", sel_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule